// File: doc/BRIEF.md
# Booth-Recoded Coefficient Multiplier

This block forms the exact signed product of a 32-bit two's-complement data word and a 7-bit two's-complement convolution weight. It sits in the multiply stage of a convolution datapath, and each kernel tap feeds one such multiplier. The weight is recoded into four radix-4 signed digits. Each digit selects zero, plus or minus one times the data word, or plus or minus two times the data word. This gives four partial products.

The four partial products are sign-extended and shifted by two bits per digit. A single row of 4:2 compressor cells, one per result bit, reduces them. A final carry-propagate addition resolves the row's sum and carry vectors, together with the +1 corrections that negated digits need. An optional output register, on by default, captures the 39-bit product. The block has no control state. Its only sequential element is that output register, which an asynchronous active-low reset clears.

Top module: `booth_coef_mult`

## Requirements
- R1: With the output register on, `prod_out` equals the exact signed product `data_in * coef_in`, as a 39-bit two's-complement value, one clock edge after the inputs are presented.
- R2: While `rst_n` is low, `prod_out` is 0. Right after release it stays 0 until the first capture.
- R3: A weight of 0 gives a product of 0 for every data word.
- R4: Digit k (k = 0..3) is read from weight bits {2k+1, 2k, 2k-1}. Bit -1 is 0 and bit 7 repeats bit 6. Codes 000 and 111 select 0, 001 and 010 select +M, 011 selects +2M, 100 selects -2M, and 101 and 110 select -M. The selected value has weight 4^k.
- R5: A weight of -64 times the data word 0x80000000 gives +2^37 (0x2000000000) with no overflow.
- R6: A weight of +63 times the data word 0x7FFFFFFF gives 0x1F7FFFFFC1.
- R7: A data word of 0 gives a product of 0 for every weight.
- R8: The compressor row plus the final resolution equals the modulo-2^39 sum of the four aligned operands, the carry-in at bit 0 and the correction bits at positions 2, 4 and 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 32 | Signed data word (multiplicand) |
| coef_in | input | 7 | Signed kernel weight (multiplier) |
| prod_out | output | 39 | Signed product |

## Verification
The hardest cases to reach are a negated double digit (code 100) applied to the most negative data word, and the long carry-out ripple through the compressor row that occurs when ones-complemented operands line up with the corrections. Both depend jointly on the exact weight and on the data bit pattern. To reach them, the stimulus sweeps all 128 weights against every corner data word (0, ±1, the two extremes and alternating-bit patterns) and against a set of pseudo-random words. Each result is compared with a 64-bit arithmetic product computed in the bench.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

    // Signed radix-4 digit selected by one recoding group
    typedef enum logic [2:0] {
        DIG_ZERO = 3'd0,
        DIG_POS1 = 3'd1,
        DIG_POS2 = 3'd2,
        DIG_NEG2 = 3'd3,
        DIG_NEG1 = 3'd4
    } booth_dig_e;

    function automatic booth_dig_e decode_group(input logic [2:0] grp);
        booth_dig_e d;
        unique case (grp)
            3'b000:  d = DIG_ZERO;
            3'b001:  d = DIG_POS1;
            3'b010:  d = DIG_POS1;
            3'b011:  d = DIG_POS2;
            3'b100:  d = DIG_NEG2;
            3'b101:  d = DIG_NEG1;
            3'b110:  d = DIG_NEG1;
            default: d = DIG_ZERO;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/bcm_pp_sel.sv
module bcm_pp_sel
    import bcm_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] mcand,
    input  logic [2:0]    grp,
    output logic [DW:0]   pp_bits,
    output logic          neg
);
    booth_dig_e   dig;
    logic [DW:0]  mag;

    always_comb begin
        dig = decode_group(grp);
        unique case (dig)
            DIG_POS1, DIG_NEG1: mag = {mcand[DW-1], mcand};
            DIG_POS2, DIG_NEG2: mag = {mcand, 1'b0};
            default:            mag = '0;
        endcase
        neg     = (dig == DIG_NEG1) || (dig == DIG_NEG2);
        pp_bits = neg ? ~mag : mag;
    end

    always_comb begin
        if (grp == 3'b000 || grp == 3'b111) begin
            AST_IDLE_GROUP: assert (pp_bits == '0 && !neg); // R4
        end
        if (grp == 3'b011) begin
            AST_DOUBLE_POS: assert (!neg && pp_bits[0] == 1'b0); // R4
        end
    end

endmodule

// File: rtl/bcm_cmp42.sv
module bcm_cmp42 (
    input  logic b0,
    input  logic b1,
    input  logic b2,
    input  logic b3,
    input  logic cin,
    output logic sum,
    output logic carry,
    output logic cout
);
    logic s1;

    always_comb begin
        s1    = b0 ^ b1 ^ b2;
        cout  = (b0 & b1) | (b0 & b2) | (b1 & b2);
        sum   = s1 ^ b3 ^ cin;
        carry = (s1 & b3) | (s1 & cin) | (b3 & cin);
    end

    always_comb begin
        AST_CELL_WEIGHT: assert ({2'b00, sum} + {1'b0, carry, 1'b0} + {1'b0, cout, 1'b0}
                                 == {2'b00, b0} + {2'b00, b1} + {2'b00, b2} + {2'b00, b3} + {2'b00, cin}); // R8
    end

endmodule

// File: rtl/bcm_cmp42_row.sv
module bcm_cmp42_row #(
    parameter int W = 39
) (
    input  logic [W-1:0] op0,
    input  logic [W-1:0] op1,
    input  logic [W-1:0] op2,
    input  logic [W-1:0] op3,
    input  logic         cin0,
    input  logic [W-1:0] corr,
    output logic [W-1:0] total
);
    logic [W-1:0] sum_v;
    logic [W-1:0] carry_v;
    logic [W-1:0] cout_v;
    logic [W-1:0] cin_v;
    logic         unused_top;

    assign cin_v[0] = cin0;

    for (genvar i = 0; i < W; i++) begin : g_cell
        if (i > 0) begin : g_chain
            assign cin_v[i] = cout_v[i-1];
        end
        bcm_cmp42 cell_i (
            .b0    (op0[i]),
            .b1    (op1[i]),
            .b2    (op2[i]),
            .b3    (op3[i]),
            .cin   (cin_v[i]),
            .sum   (sum_v[i]),
            .carry (carry_v[i]),
            .cout  (cout_v[i])
        );
    end

    assign unused_top = cout_v[W-1] ^ carry_v[W-1];
    assign total = sum_v + {carry_v[W-2:0], 1'b0} + corr;

    always_comb begin
        AST_ROW_TOTAL: assert (total == op0 + op1 + op2 + op3 + W'(cin0) + corr); // R8
    end

endmodule

// File: rtl/booth_coef_mult.sv
module booth_coef_mult #(
    parameter int DW      = 32,
    parameter int CW      = 7,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DW-1:0]        data_in,
    input  logic [CW-1:0]        coef_in,
    output logic [DW+CW-1:0]     prod_out
);
    localparam int NG = (CW + 1) / 2;       // recoding groups (4)
    localparam int EW = 2 * NG + 1;         // extended weight width
    localparam int SX = 2 * NG - CW;        // sign copies above the weight
    localparam int PW = DW + CW;            // product width (39)
    localparam int XW = PW - DW - 1;        // extension of a selected value

    logic [EW-1:0] coef_ext;
    logic [DW:0]   pp_bits [NG];
    logic [NG-1:0] neg;
    logic [PW-1:0] aligned [NG];
    logic [PW-1:0] corr;
    logic [PW-1:0] prod_comb;

    assign coef_ext = {{SX{coef_in[CW-1]}}, coef_in, 1'b0};

    for (genvar k = 0; k < NG; k++) begin : g_grp
        bcm_pp_sel #(.DW(DW)) sel_i (
            .mcand   (data_in),
            .grp     (coef_ext[2*k+2:2*k]),
            .pp_bits (pp_bits[k]),
            .neg     (neg[k])
        );
        assign aligned[k] = {{XW{pp_bits[k][DW]}}, pp_bits[k]} << (2 * k);
    end

    always_comb begin
        corr = '0;
        for (int k = 1; k < NG; k++) begin
            corr[2*k] = neg[k];
        end
    end

    bcm_cmp42_row #(.W(PW)) row_i (
        .op0   (aligned[0]),
        .op1   (aligned[1]),
        .op2   (aligned[2]),
        .op3   (aligned[3]),
        .cin0  (neg[0]),
        .corr  (corr),
        .total (prod_comb)
    );

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prod_out <= '0;
            else        prod_out <= prod_comb;
        end

        AST_ZERO_COEF: assert property (@(posedge clk) disable iff (!rst_n)
            (coef_in == '0) |=> (prod_out == '0)); // R3
        AST_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
            (data_in == '0) |=> (prod_out == '0)); // R7
        AST_UNIT_COEF: assert property (@(posedge clk) disable iff (!rst_n)
            (coef_in == CW'(1)) |=> (prod_out == PW'($signed($past(data_in))))); // R1
        AST_NEG_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
            (coef_in == '1) |=> (prod_out == -PW'($signed($past(data_in))))); // R1
        AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> (prod_out == '0)); // R2
    end else begin : g_comb
        assign prod_out = prod_comb;

        AST_ZERO_COEF: assert property (@(posedge clk) disable iff (!rst_n)
            (coef_in == '0) |-> (prod_out == '0)); // R3
        AST_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
            (data_in == '0) |-> (prod_out == '0)); // R7
    end

endmodule

// File: tb/booth_coef_mult_tb.sv
module booth_coef_mult_tb_top;
    localparam int DW = 32;
    localparam int CW = 7;
    localparam int PW = DW + CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic [CW-1:0] coef_in = '0;
    logic [PW-1:0] prod_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    booth_coef_mult #(.DW(DW), .CW(CW), .OUT_REG(1'b1)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_in  (data_in),
        .coef_in  (coef_in),
        .prod_out (prod_out)
    );

    function automatic logic [31:0] xs32(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s data=%h coef=%h actual=%h expected=%h", req, data_in, coef_in, act, exp);
        end
    endtask

    task automatic apply(input logic [DW-1:0] d, input logic [CW-1:0] c, input string req);
        longint  e;
        @(negedge clk);
        data_in = d;
        coef_in = c;
        e = longint'($signed(d)) * longint'($signed(c));
        @(negedge clk);
        check(req, prod_out, e[PW-1:0]);
    endtask

    initial begin
        logic [31:0] seed;
        logic [31:0] corners [7];
        string       tag;
        corners[0] = 32'h0000_0000;
        corners[1] = 32'h0000_0001;
        corners[2] = 32'hFFFF_FFFF;
        corners[3] = 32'h7FFF_FFFF;
        corners[4] = 32'h8000_0000;
        corners[5] = 32'h5555_5555;
        corners[6] = 32'hAAAA_AAAA;

        // R2: output held at zero under reset with live inputs
        data_in = 32'h1234_5678;
        coef_in = 7'h2B;
        repeat (3) @(negedge clk);
        check("R2", prod_out, '0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R2", prod_out, PW'(longint'($signed(32'h1234_5678)) * 43));

        // R5 and R6: extreme corners
        apply(32'h8000_0000, 7'h40, "R5");
        check("R5", prod_out, 39'h20_0000_0000);
        apply(32'h7FFF_FFFF, 7'h3F, "R6");
        check("R6", prod_out, 39'h1F_7FFF_FFC1);

        // Full weight sweep against corner words: R1, R3, R4, R7, R8
        for (int c = 0; c < 128; c++) begin
            for (int j = 0; j < 7; j++) begin
                if (c == 0)               tag = "R3";
                else if (corners[j] == 0) tag = "R7";
                else                      tag = "R1,R4,R8";
                apply(corners[j], CW'(c), tag);
            end
        end

        // Full weight sweep against pseudo-random words: R1, R4, R8
        seed = 32'h1ACE_B00C;
        for (int n = 0; n < 24; n++) begin
            seed = xs32(seed);
            for (int c = 0; c < 128; c++) begin
                apply(seed, CW'(c), (c == 0) ? "R3" : "R1,R4,R8");
            end
        end

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                bad++;
                total++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule